// File: doc/BRIEF.md
# TLB Management Register Interface

This block is the software-facing register file of a translation unit's entry store. A processor reaches it through a small register-number port with separate write and read strobes. It holds an index register, an address-space ID register, a zone-access register and a sticky error flag. Software reads and writes the two words of a translation entry indirectly, with the index register selecting the entry. A search register hands a page number to the external lookup logic and records the result in the index register.

The entry words live in storage outside the block. The block drives that storage's index, write data and per-word write enables, and takes back the addressed entry's words combinationally. It keeps a translation ID and a valid bit for every entry. From these it tells downstream translation caches what to drop: one entry when its high word is rewritten, every entry owned by the outgoing ID when the ID register changes, and everything when the zone-access value changes. An access-level input limits what software may do.

Top module: `tlb_mgmt_regs`

## Requirements
- R1: Register numbers are 0x0 for the entry low word, 0x1 for the entry high word, 0x2 for index, 0x3 for ID, 0x4 for zone, 0x5 for search and 0x6 for error. Entry words are reached at the entry given by bits 7:0 of the index register, with bit 0 of the register number choosing the high word. Read data appears on `rdata_o` in the cycle after the read strobe.
- R2: A high-word write stores ID bits 7:0 as that entry's translation ID and bit 6 of the written value as its valid bit. In the same cycle it pulses `inval_one_o` with `inval_idx_o` equal to the entry index.
- R3: Reading the high word loads that entry's stored translation ID into the ID register.
- R4: A search write asserts `search_req_o` with the written value's bits 9:0 cleared. On a hit the index register takes the returned index. On a miss, index bit 31 is set and its other bits are unchanged.
- R5: A zone write pulses `flush_all_o` in the same cycle only when the new value differs from the stored one.
- R6: An ID write whose value differs from the stored ID sets `inval_mask_o` bit i, in the same cycle, for every entry i that is valid and has a nonzero translation ID equal to the outgoing ID. An unchanged value sets no bit.
- R7: At access level 0, reads return zero and no write has any effect. At level 1, writes to ID, zone and search are ignored and reads work. Levels 2 and 3 allow everything.
- R8: After reset the index, ID and zone registers, the error flag, all translation IDs and `rdata_o` are zero.
- R9: Bit 0 of the error register is set, and stays set, after any of three events: an access refused under R7, an ID write with any bit above bit 7 set (bits 7:0 are still stored), or an entry access with index bits 7:0 at or above the entry count, which is then ignored. A write to the error register at level 1 or above clears it.
- R10: Register numbers 0x7 to 0xF are plain 32-bit storage. The search register reads as zero. When both strobes are high, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| access_lvl_i | input | 2 | Software access level |
| reg_num_i | input | 4 | Register number |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| entry_idx_o | output | IDX_W | Entry index for storage |
| entry_wdata_o | output | 32 | Entry write data |
| entry_we_lo_o | output | 1 | Low-word write enable |
| entry_we_hi_o | output | 1 | High-word write enable |
| entry_rdata_lo_i | input | 32 | Addressed low word |
| entry_rdata_hi_i | input | 32 | Addressed high word |
| search_req_o | output | 1 | Lookup request |
| search_page_o | output | 32 | Page number to look up |
| search_hit_i | input | 1 | Lookup hit |
| search_idx_i | input | IDX_W | Index of the hitting entry |
| inval_one_o | output | 1 | Single-entry invalidate pulse |
| inval_idx_o | output | IDX_W | Entry to invalidate |
| inval_mask_o | output | ENTRIES | Per-entry invalidate on ID change |
| flush_all_o | output | 1 | Global flush pulse |

## Verification
A stale translation ID is invisible until one of two things happens: the high word is read back and the ID register is then read, or an ID change fails to raise the expected bit in `inval_mask_o`. The bench therefore drives both paths. A corrupted index register shows at once as the wrong entry on the storage port and in the next read of the index register. A lost error flag shows only on the next error-register read after a refused access, so the bench reads it right after each kind of refusal. The invalidate and flush outputs are combinational in the write cycle, so any fault in them is visible in that same cycle.

// File: rtl/tlb_mgmt_pkg.sv
package tlb_mgmt_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned RN_W    = 4;
  localparam int unsigned TID_W   = 8;
  localparam int unsigned SEL_W   = 8;

  localparam logic [RN_W-1:0] RN_ENT_LO = 4'h0;
  localparam logic [RN_W-1:0] RN_ENT_HI = 4'h1;
  localparam logic [RN_W-1:0] RN_INDEX  = 4'h2;
  localparam logic [RN_W-1:0] RN_ASID   = 4'h3;
  localparam logic [RN_W-1:0] RN_ZONE   = 4'h4;
  localparam logic [RN_W-1:0] RN_SEARCH = 4'h5;
  localparam logic [RN_W-1:0] RN_ERR    = 4'h6;
  localparam logic [RN_W-1:0] RN_SCR0   = 4'h7;
  localparam int unsigned     SCR_N     = 16 - 7;

  typedef struct packed {
    logic lo_wr;
    logic hi_wr;
    logic hi_rd;
    logic idx_wr;
    logic asid_wr;
    logic zone_wr;
    logic srch_wr;
    logic err_wr;
    logic scr_wr;
    logic rd_en;
    logic rd_ok;
    logic denied;
  } acc_dec_t;
endpackage

// File: rtl/tlb_acc_decode.sv
module tlb_acc_decode
  import tlb_mgmt_pkg::*;
(
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [RN_W-1:0] reg_num_i,
  input  logic [1:0]      access_lvl_i,
  input  logic            idx_ok_i,
  output acc_dec_t        dec_o
);
  logic lvl_any, lvl_full, is_ent, rd_eff, wr_ok, restricted;

  always_comb begin
    lvl_any    = access_lvl_i != 2'd0;
    lvl_full   = access_lvl_i[1];
    is_ent     = reg_num_i[RN_W-1:1] == '0;
    rd_eff     = rd_i && !wr_i;  // write wins
    wr_ok      = wr_i && lvl_any;
    restricted = reg_num_i == RN_ASID || reg_num_i == RN_ZONE || reg_num_i == RN_SEARCH;

    dec_o.lo_wr   = wr_ok && is_ent && !reg_num_i[0] && idx_ok_i;
    dec_o.hi_wr   = wr_ok && is_ent &&  reg_num_i[0] && idx_ok_i;
    dec_o.hi_rd   = rd_eff && lvl_any && is_ent && reg_num_i[0] && idx_ok_i;
    dec_o.idx_wr  = wr_ok && reg_num_i == RN_INDEX;
    dec_o.asid_wr = wr_ok && lvl_full && reg_num_i == RN_ASID;
    dec_o.zone_wr = wr_ok && lvl_full && reg_num_i == RN_ZONE;
    dec_o.srch_wr = wr_ok && lvl_full && reg_num_i == RN_SEARCH;
    dec_o.err_wr  = wr_ok && reg_num_i == RN_ERR;
    dec_o.scr_wr  = wr_ok && reg_num_i >= RN_SCR0;
    dec_o.rd_en   = rd_eff;
    dec_o.rd_ok   = rd_eff && lvl_any && !(is_ent && !idx_ok_i);
    dec_o.denied  = (wr_i || rd_eff) &&
                    (!lvl_any || (wr_i && !lvl_full && restricted) || (is_ent && !idx_ok_i));
  end
endmodule

// File: rtl/tlb_tid_store.sv
module tlb_tid_store
  import tlb_mgmt_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               we_i,
  input  logic [TID_W-1:0]   wtid_i,
  input  logic               wvld_i,
  output logic [TID_W-1:0]   rtid_o,
  input  logic               chg_i,
  input  logic [TID_W-1:0]   old_id_i,
  output logic [ENTRIES-1:0] mask_o
);
  logic [TID_W-1:0] tid_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tid_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (we_i && idx_i == IDX_W'(g)) begin
        tid_q[g] <= wtid_i;
        vld_q[g] <= wvld_i;
      end
    end
    assign mask_o[g] = chg_i && vld_q[g] && tid_q[g] != '0 && tid_q[g] == old_id_i;
  end

  assign rtid_o = tid_q[idx_i];
endmodule

// File: rtl/tlb_mgmt_regs.sv
module tlb_mgmt_regs
  import tlb_mgmt_pkg::*;
#(
  parameter int unsigned ENTRIES    = 64,
  parameter int unsigned PAGE_SHIFT = 10,
  parameter int unsigned VALID_BIT  = 6,
  localparam int unsigned IDX_W     = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         access_lvl_i,
  input  logic [RN_W-1:0]    reg_num_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_i,
  input  logic               rd_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [IDX_W-1:0]   entry_idx_o,
  output logic [DATA_W-1:0]  entry_wdata_o,
  output logic               entry_we_lo_o,
  output logic               entry_we_hi_o,
  input  logic [DATA_W-1:0]  entry_rdata_lo_i,
  input  logic [DATA_W-1:0]  entry_rdata_hi_i,
  output logic               search_req_o,
  output logic [DATA_W-1:0]  search_page_o,
  input  logic               search_hit_i,
  input  logic [IDX_W-1:0]   search_idx_i,
  output logic               inval_one_o,
  output logic [IDX_W-1:0]   inval_idx_o,
  output logic [ENTRIES-1:0] inval_mask_o,
  output logic               flush_all_o
);
  localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1));

  logic [DATA_W-1:0] idx_q, zone_q, rdata_q, rd_mux;
  logic [TID_W-1:0]  asid_q, cur_tid;
  logic              err_q, idx_ok, asid_chg, asid_bad;
  logic [DATA_W-1:0] scr_q [SCR_N];
  logic [RN_W-1:0]   scr_sel;
  acc_dec_t          dec;

  assign idx_ok   = {1'b0, idx_q[SEL_W-1:0]} < (SEL_W+1)'(ENTRIES);
  assign asid_chg = dec.asid_wr && wdata_i != {{(DATA_W-TID_W){1'b0}}, asid_q};
  assign asid_bad = dec.asid_wr && |wdata_i[DATA_W-1:TID_W];
  assign scr_sel  = reg_num_i - RN_SCR0;

  tlb_acc_decode u_dec (
    .wr_i         (wr_i),
    .rd_i         (rd_i),
    .reg_num_i    (reg_num_i),
    .access_lvl_i (access_lvl_i),
    .idx_ok_i     (idx_ok),
    .dec_o        (dec)
  );

  tlb_tid_store #(.ENTRIES(ENTRIES)) u_tid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_i    (entry_idx_o),
    .we_i     (dec.hi_wr),
    .wtid_i   (asid_q),
    .wvld_i   (wdata_i[VALID_BIT]),
    .rtid_o   (cur_tid),
    .chg_i    (asid_chg),
    .old_id_i (asid_q),
    .mask_o   (inval_mask_o)
  );

  always_comb begin
    unique case (reg_num_i)
      RN_ENT_LO: rd_mux = entry_rdata_lo_i;
      RN_ENT_HI: rd_mux = entry_rdata_hi_i;
      RN_INDEX:  rd_mux = idx_q;
      RN_ASID:   rd_mux = {{(DATA_W-TID_W){1'b0}}, asid_q};
      RN_ZONE:   rd_mux = zone_q;
      RN_SEARCH: rd_mux = '0;
      RN_ERR:    rd_mux = {{(DATA_W-1){1'b0}}, err_q};
      default:   rd_mux = scr_q[scr_sel];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      asid_q  <= '0;
      zone_q  <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (dec.idx_wr)       idx_q <= wdata_i;
      else if (dec.srch_wr) idx_q <= search_hit_i ? DATA_W'(search_idx_i)
                                                  : (idx_q | {1'b1, {(DATA_W-1){1'b0}}});
      if (dec.asid_wr)      asid_q <= wdata_i[TID_W-1:0];
      else if (dec.hi_rd)   asid_q <= cur_tid;
      if (dec.zone_wr)      zone_q <= wdata_i;
      if (dec.denied || asid_bad) err_q <= 1'b1;
      else if (dec.err_wr)        err_q <= 1'b0;
      if (dec.rd_en)        rdata_q <= dec.rd_ok ? rd_mux : '0;
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  scr_q[g] <= '0;
      else if (dec.scr_wr && scr_sel == RN_W'(g))   scr_q[g] <= wdata_i;
    end
  end

  assign rdata_o       = rdata_q;
  assign entry_idx_o   = idx_q[IDX_W-1:0];
  assign entry_wdata_o = wdata_i;
  assign entry_we_lo_o = dec.lo_wr;
  assign entry_we_hi_o = dec.hi_wr;
  assign inval_one_o   = dec.hi_wr;
  assign inval_idx_o   = idx_q[IDX_W-1:0];
  assign search_req_o  = dec.srch_wr;
  assign search_page_o = wdata_i & PAGE_MASK;
  assign flush_all_o   = dec.zone_wr && wdata_i != zone_q;
endmodule

// File: rtl/tlb_mgmt_regs_chk.sv
module tlb_mgmt_regs_chk
  import tlb_mgmt_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         access_lvl_i,
  input logic [RN_W-1:0]    reg_num_i,
  input logic               wr_i,
  input logic               rd_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               entry_we_lo_o,
  input logic               entry_we_hi_o,
  input logic               search_req_o,
  input logic               search_hit_i,
  input logic [ENTRIES-1:0] inval_mask_o,
  input logic               flush_all_o,
  input logic [DATA_W-1:0]  idx_q,
  input logic               err_q
);
  // R2
  hi_write_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_we_hi_o |-> wr_i && reg_num_i == RN_ENT_HI);

  // R4
  search_miss_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_req_o && !search_hit_i |=> idx_q[DATA_W-1]);

  // R5
  flush_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_o |-> wr_i && reg_num_i == RN_ZONE && access_lvl_i[1]);

  // R6
  mask_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|inval_mask_o) |-> wr_i && reg_num_i == RN_ASID && access_lvl_i[1]);

  // R7
  lvl0_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_lvl_i == 2'd0 |-> !entry_we_lo_o && !entry_we_hi_o && !search_req_o && !flush_all_o);

  // R7
  lvl1_restrict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_lvl_i == 2'd1 |-> !search_req_o && !flush_all_o && inval_mask_o == '0);

  // R7
  lvl0_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && access_lvl_i == 2'd0 |=> rdata_o == '0);

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !(wr_i && reg_num_i == RN_ERR) |=> err_q);
endmodule

bind tlb_mgmt_regs tlb_mgmt_regs_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .access_lvl_i  (access_lvl_i),
  .reg_num_i     (reg_num_i),
  .wr_i          (wr_i),
  .rd_i          (rd_i),
  .rdata_o       (rdata_o),
  .entry_we_lo_o (entry_we_lo_o),
  .entry_we_hi_o (entry_we_hi_o),
  .search_req_o  (search_req_o),
  .search_hit_i  (search_hit_i),
  .inval_mask_o  (inval_mask_o),
  .flush_all_o   (flush_all_o),
  .idx_q         (idx_q),
  .err_q         (err_q)
);

// File: tb/tb_tlb_mgmt_regs.sv
module tb_tlb_mgmt_regs;
  localparam int unsigned ENTRIES = 64;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);

  typedef struct packed {
    logic        is_rd;
    logic [3:0]  rn;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  // R1 R2 R3 R4 R5 R10 R9 exercised below
  localparam vec_t [0:NV-1] VECS = '{
    '{1'b0, 4'h2, 32'h0000_0005, 32'h0, 4'd1},
    '{1'b0, 4'h3, 32'h0000_0012, 32'h0, 4'd2},
    '{1'b0, 4'h1, 32'hABCD_0440, 32'h0, 4'd2},
    '{1'b0, 4'h0, 32'h1111_2222, 32'h0, 4'd1},
    '{1'b1, 4'h0, 32'h0, 32'h1111_2222, 4'd1},
    '{1'b1, 4'h1, 32'h0, 32'hABCD_0440, 4'd1},
    '{1'b0, 4'h3, 32'h0000_0000, 32'h0, 4'd3},
    '{1'b1, 4'h3, 32'h0, 32'h0000_0000, 4'd3},
    '{1'b1, 4'h1, 32'h0, 32'hABCD_0440, 4'd3},
    '{1'b1, 4'h3, 32'h0, 32'h0000_0012, 4'd3},
    '{1'b0, 4'h2, 32'h0000_0007, 32'h0, 4'd4},
    '{1'b0, 4'h5, 32'hABCD_07FF, 32'h0, 4'd4},
    '{1'b1, 4'h2, 32'h0, 32'h0000_0005, 4'd4},
    '{1'b0, 4'h5, 32'h1234_0000, 32'h0, 4'd4},
    '{1'b1, 4'h2, 32'h0, 32'h8000_0005, 4'd4},
    '{1'b0, 4'h4, 32'hC000_0000, 32'h0, 4'd5},
    '{1'b1, 4'h4, 32'h0, 32'hC000_0000, 4'd5},
    '{1'b0, 4'h9, 32'hDEAD_BEEF, 32'h0, 4'd10},
    '{1'b1, 4'h9, 32'h0, 32'hDEAD_BEEF, 4'd10},
    '{1'b1, 4'hF, 32'h0, 32'h0000_0000, 4'd10},
    '{1'b1, 4'h5, 32'h0, 32'h0000_0000, 4'd10},
    '{1'b1, 4'h6, 32'h0, 32'h0000_0000, 4'd9}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         lvl = 2'd2;
  logic [3:0]         rn = '0;
  logic [31:0]        wdata = '0;
  logic               wr = 1'b0, rd = 1'b0;
  logic [31:0]        rdata;
  logic [IDX_W-1:0]   e_idx, s_idx, i_idx;
  logic [31:0]        e_wdata, s_page;
  logic               we_lo, we_hi, s_req, s_hit, i_one, f_all;
  logic [ENTRIES-1:0] i_mask;
  logic [31:0]        lo_mem [ENTRIES];
  logic [31:0]        hi_mem [ENTRIES];

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic               c_flush, c_one, c_srch, c_welo;
  logic [IDX_W-1:0]   c_idx;
  logic [ENTRIES-1:0] c_mask;

  always #10 clk = ~clk;

  tlb_mgmt_regs #(.ENTRIES(ENTRIES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .access_lvl_i(lvl), .reg_num_i(rn),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
    .entry_idx_o(e_idx), .entry_wdata_o(e_wdata),
    .entry_we_lo_o(we_lo), .entry_we_hi_o(we_hi),
    .entry_rdata_lo_i(lo_mem[e_idx]), .entry_rdata_hi_i(hi_mem[e_idx]),
    .search_req_o(s_req), .search_page_o(s_page),
    .search_hit_i(s_hit), .search_idx_i(s_idx),
    .inval_one_o(i_one), .inval_idx_o(i_idx),
    .inval_mask_o(i_mask), .flush_all_o(f_all)
  );

  initial for (int i = 0; i < ENTRIES; i++) begin lo_mem[i] = '0; hi_mem[i] = '0; end

  always @(posedge clk) begin
    if (we_lo) lo_mem[e_idx] <= e_wdata;
    if (we_hi) hi_mem[e_idx] <= e_wdata;
  end

  // external lookup model: lowest valid entry with matching page
  always_comb begin
    s_hit = 1'b0;
    s_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hi_mem[i][6] && hi_mem[i][31:10] == s_page[31:10]) begin
        s_hit = 1'b1;
        s_idx = IDX_W'(i);
      end
  end

  task automatic acc(input logic w, input logic [3:0] r, input logic [31:0] d, input logic [1:0] l);
    @(negedge clk);
    wr = w; rd = !w; rn = r; wdata = d; lvl = l;
    #5;
    c_flush = f_all; c_one = i_one; c_idx = i_idx; c_mask = i_mask;
    c_srch = s_req; c_welo = we_lo;
    @(posedge clk);
    #1;
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk("R8 rdata", 64'(rdata), 0);
    acc(1'b0, 4'h2, 0, 2'd2); chk("R8 index", 64'(rdata), 0);
    acc(1'b0, 4'h3, 0, 2'd2); chk("R8 id", 64'(rdata), 0);
    acc(1'b0, 4'h4, 0, 2'd2); chk("R8 zone", 64'(rdata), 0);
    acc(1'b0, 4'h6, 0, 2'd2); chk("R8 err", 64'(rdata), 0);

    for (int v = 0; v < NV; v++) begin
      acc(!VECS[v].is_rd, VECS[v].rn, VECS[v].dat, 2'd2);
      if (VECS[v].is_rd) begin
        checks++;
        if (rdata !== VECS[v].exp) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%0h expected=%0h", VECS[v].req, v, rdata, VECS[v].exp);
        end
      end
    end

    // R2 single invalidate on high write (entry 3 left invalid)
    acc(1'b1, 4'h2, 32'd3, 2'd2);
    acc(1'b1, 4'h1, 32'h0, 2'd2);
    chk("R2 inval_one", 64'(c_one), 1);
    chk("R2 inval_idx", 64'(c_idx), 3);
    // R6 ID change invalidates entry 5 only (owner 0x12, valid)
    acc(1'b1, 4'h3, 32'h34, 2'd2);
    chk("R6 mask", 64'(c_mask), 64'h20);
    acc(1'b1, 4'h3, 32'h34, 2'd2);
    chk("R6 unchanged", 64'(c_mask), 0);
    // R5 zone flush only on change
    acc(1'b1, 4'h4, 32'hC000_0000, 2'd2);
    chk("R5 same", 64'(c_flush), 0);
    acc(1'b1, 4'h4, 32'h1, 2'd2);
    chk("R5 differ", 64'(c_flush), 1);
    // R7 level 1 and level 0
    acc(1'b1, 4'h3, 32'h55, 2'd1);
    chk("R7 l1 mask", 64'(c_mask), 0);
    acc(1'b0, 4'h3, 0, 2'd1);
    chk("R7 l1 id kept", 64'(rdata), 64'h34);
    acc(1'b1, 4'h4, 32'h7, 2'd1);
    chk("R7 l1 zone", 64'(c_flush), 0);
    acc(1'b1, 4'h5, 32'hABCD_0400, 2'd1);
    chk("R7 l1 search", 64'(c_srch), 0);
    acc(1'b0, 4'h2, 0, 2'd0);
    chk("R7 l0 read", 64'(rdata), 0);
    acc(1'b1, 4'h2, 32'd9, 2'd0);
    acc(1'b0, 4'h2, 0, 2'd2);
    chk("R7 l0 write", 64'(rdata), 3);
    // R9 sticky error
    acc(1'b0, 4'h6, 0, 2'd2);
    chk("R9 set", 64'(rdata), 1);
    acc(1'b1, 4'h6, 0, 2'd2);
    acc(1'b0, 4'h6, 0, 2'd2);
    chk("R9 cleared", 64'(rdata), 0);
    acc(1'b1, 4'h3, 32'h1FF, 2'd2);
    acc(1'b0, 4'h6, 0, 2'd2);
    chk("R9 id high bits", 64'(rdata), 1);
    acc(1'b0, 4'h3, 0, 2'd2);
    chk("R9 id low kept", 64'(rdata), 64'hFF);
    acc(1'b1, 4'h6, 0, 2'd2);
    acc(1'b1, 4'h2, 32'd100, 2'd2);
    acc(1'b1, 4'h0, 32'h77, 2'd2);
    chk("R9 range we", 64'(c_welo), 0);
    acc(1'b0, 4'h6, 0, 2'd2);
    chk("R9 range err", 64'(rdata), 1);
    // R10 write wins over simultaneous read
    @(negedge clk);
    wr = 1'b1; rd = 1'b1; rn = 4'h7; wdata = 32'h0BAD_F00D; lvl = 2'd2;
    @(posedge clk); #1 wr = 1'b0; rd = 1'b0;
    chk("R10 rdata held", 64'(rdata), 1);
    acc(1'b0, 4'h7, 0, 2'd2);
    chk("R10 scratch", 64'(rdata), 64'h0BAD_F00D);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule